// File: doc/BRIEF.md
# Serial Register-Access Target

This block is a four-wire serial target that lets an external master read and write a bank of eight-bit registers. The master lowers an active-low select, then clocks in a command byte whose top bit chooses read or write, whose next bit chooses address auto-increment, and whose low six bits give the starting register. Any number of data bytes follow while select stays low. Write bytes go into the addressed registers. Read bytes come back on the data-out line. The serial clock idles high.

The block runs from a system clock that is much faster than the serial clock. Select, serial clock and data in each pass through a synchroniser. Edges of the serial clock are found in the system-clock domain. Input data is taken on rising serial-clock edges and output data is changed on falling ones. The data-out driver is shown as a value plus an output enable, and the enable is only high while the frame is selected.

Top module: `spi_regs_slave`

## Requirements
- R1: After reset every register holds 0x00, miso_oe_o is low and miso_o is low.
- R2: miso_oe_o is high while the synchronised select is low and goes low within a few system cycles after select rises.
- R3: Command byte layout: bit 7 is the direction (1 = read, 0 = write), bit 6 is the auto-increment flag, and bits 5..0 are the register address. The byte is sent most significant bit first.
- R4: In a write frame, each complete data byte, taken MSB first on rising serial-clock edges, is stored at the current address.
- R5: In a read frame, the first data bit (the register's bit 7) appears on miso_o after the falling edge that follows the last command bit. Later bits follow MSB first, and miso_o changes only after falling serial-clock edges or when select rises.
- R6: With auto-increment set, the address goes up by one after each data byte and wraps from 63 to 0.
- R7: With auto-increment clear, every data byte in the frame uses the command's address. The last write wins and repeated reads return the same register.
- R8: If select rises partway through a byte, that byte is dropped and no register changes. The next frame starts again with a command byte.
- R9: Read frames leave the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low frame select from the master |
| sclk_i | input | 1 | Serial clock from the master, idle high |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for miso_o; low means high-impedance |

## Verification
The bench writes at addresses 62 and 63 with auto-increment set and checks that the third byte lands at address 0. A design that saturates or carries into the flag bits would corrupt that byte. It writes several bytes with auto-increment clear and checks that only the last one remains. It also drops select four bits into a byte, after which a design that commits partial bytes would show a half-shifted value on read-back. Read timing is checked by sampling each bit on the rising edge and again just before the next falling edge. A design that shifts on the wrong edge, or one byte late, returns shifted data or changes while the clock is high.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    // Bit positions inside the command byte (counted from the MSB end)
    localparam int CMD_DIR_OFS = 1;  // offset from the top: direction flag
    localparam int CMD_INC_OFS = 2;  // offset from the top: auto-increment flag
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] stg_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= RST_VAL;
                else        stg_q <= d_i;
            end
            assign q_o = stg_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= {STAGES{RST_VAL}};
                else        stg_q <= {stg_q[STAGES-2:0], d_i};
            end
            assign q_o = stg_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_regs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s_i,
    input  logic              sclk_s_i,
    input  logic              mosi_s_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [ADDR_W-1:0] raddr_o,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              miso_o,
    output logic              miso_oe_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  bit_cnt;
        logic [DATA_W-1:0] shreg;
        logic              rd;
        logic              inc;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] tx;
        logic              miso;
        logic              oe;
        logic              sclk_prev;
    } frame_t;

    frame_t q, d;
    logic              rise, fall;
    logic [DATA_W-1:0] byte_v;
    logic [ADDR_W-1:0] nxt_addr;

    always_comb begin
        d        = q;
        we_o     = 1'b0;
        waddr_o  = q.addr;
        wdata_o  = '0;
        raddr_o  = q.addr;
        rise     = sclk_s_i & ~q.sclk_prev;
        fall     = ~sclk_s_i & q.sclk_prev;
        byte_v   = {q.shreg[DATA_W-2:0], mosi_s_i};
        nxt_addr = q.inc ? q.addr + 1'b1 : q.addr;
        d.sclk_prev = sclk_s_i;

        if (cs_s_i) begin
            d.phase   = PH_CMD;
            d.bit_cnt = '0;
            d.shreg   = '0;
            d.rd      = 1'b0;
            d.inc     = 1'b0;
            d.addr    = '0;
            d.tx      = '0;
            d.miso    = 1'b0;
            d.oe      = 1'b0;
        end else begin
            d.oe = 1'b1;
            if (rise) begin
                d.shreg   = byte_v;
                d.bit_cnt = q.bit_cnt + 1'b1;
                if (q.bit_cnt == LAST_BIT) begin
                    if (q.phase == PH_CMD) begin
                        d.phase = PH_DATA;
                        d.rd    = byte_v[DATA_W-CMD_DIR_OFS];
                        d.inc   = byte_v[DATA_W-CMD_INC_OFS];
                        d.addr  = byte_v[ADDR_W-1:0];
                        raddr_o = byte_v[ADDR_W-1:0];
                        d.tx    = rdata_i;
                    end else begin
                        if (!q.rd) begin
                            we_o    = 1'b1;
                            waddr_o = q.addr;
                            wdata_o = byte_v;
                        end
                        d.addr  = nxt_addr;
                        raddr_o = nxt_addr;
                        d.tx    = rdata_i;
                    end
                end
            end else if (fall && q.phase == PH_DATA && q.rd) begin
                d.miso = q.tx[DATA_W-1];
                d.tx   = {q.tx[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.phase     <= PH_CMD;
            q.sclk_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign miso_o    = q.miso;
    assign miso_oe_o = q.oe;
endmodule

// File: rtl/spi_regs_slave.sv
module spi_regs_slave #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic mosi_i,
    output logic miso_o,
    output logic miso_oe_o
);
    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] sync_q;
    logic              cs_s, sclk_s, mosi_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    spi_sync #(
        .WIDTH  (N_SYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b110)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({cs_n_i, sclk_i, mosi_i}),
        .q_o  (sync_q)
    );

    assign cs_s   = sync_q[2];
    assign sclk_s = sync_q[1];
    assign mosi_s = sync_q[0];

    spi_frame_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s_i   (cs_s),
        .sclk_s_i (sclk_s),
        .mosi_s_i (mosi_s),
        .we_o     (wr_en),
        .waddr_o  (wr_addr),
        .wdata_o  (wr_data),
        .raddr_o  (rd_addr),
        .rdata_i  (rd_data),
        .miso_o   (miso_o),
        .miso_oe_o(miso_oe_o)
    );

    spi_regfile #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (wr_en),
        .waddr_i(wr_addr),
        .wdata_i(wr_data),
        .raddr_i(rd_addr),
        .rdata_o(rd_data)
    );
endmodule

// File: rtl/spi_regs_slave_chk.sv
module spi_regs_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sclk_s,
    input logic wr_en,
    input logic miso_o,
    input logic miso_oe_o
);
    logic sclk_prev_c;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_c <= 1'b1;
        else        sclk_prev_c <= sclk_s;
    end

    // R1: outputs quiet on leaving reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!miso_oe_o && !miso_o));

    // R2: enable drops once select is seen high
    a_r2_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso_oe_o);

    // R8: no register update while deselected
    a_r8_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> !wr_en);

    // R4: writes happen only on a rising serial-clock edge
    a_r4_write_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (sclk_s && !sclk_prev_c));

    // R5: data out moves only after a falling edge or a deselect
    a_r5_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_o != $past(miso_o)) |-> $past((sclk_prev_c && !sclk_s) || cs_s));
endmodule

bind spi_regs_slave spi_regs_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .sclk_s   (sclk_s),
    .wr_en    (wr_en),
    .miso_o   (miso_o),
    .miso_oe_o(miso_oe_o)
);

// File: tb/spi_regs_slave_tb.sv
module spi_regs_slave_tb;
    localparam int H = 6;  // system cycles per serial half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b1, mosi = 1'b0;
    logic miso, miso_oe;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] model [64];

    always #4 clk = ~clk;

    spi_regs_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
        .mosi_i(mosi), .miso_o(miso), .miso_oe_o(miso_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cmd(input bit rd, input bit inc, input logic [5:0] a);
        return {rd, inc, a};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel;
        cs_n = 1'b0;
        wait_cyc(H);
    endtask

    task automatic desel;
        wait_cyc(H);
        cs_n = 1'b1;
        wait_cyc(2 * H);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, input bit chk_hold,
                        output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            sclk = 1'b0;
            mosi = tx[i];
            wait_cyc(H);
            rx[i] = miso;
            sclk = 1'b1;
            wait_cyc(H - 1);
            if (chk_hold)
                check(miso == rx[i], "R5 miso held while clock high", miso, rx[i]);
            wait_cyc(1);
        end
    endtask

    task automatic write_frame(input bit inc, input logic [5:0] a, input logic [7:0] b [4],
                               input int n);
        logic [7:0] rx;
        logic [5:0] p = a;
        sel();
        xfer(cmd(1'b0, inc, a), 8, 1'b0, rx);
        for (int k = 0; k < n; k++) begin
            xfer(b[k], 8, 1'b0, rx);
            model[p] = b[k];
            if (inc) p = p + 1'b1;
        end
        desel();
    endtask

    task automatic read_frame(input bit inc, input logic [5:0] a, input int n, input string req);
        logic [7:0] rx;
        logic [5:0] p = a;
        sel();
        xfer(cmd(1'b1, inc, a), 8, 1'b0, rx);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8, 1'b1, rx);
            check(rx == model[p], req, rx, model[p]);
            if (inc) p = p + 1'b1;
        end
        desel();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : stim
        logic [7:0] b [4];
        logic [7:0] rx;
        int seed_v;
        seed_v = $urandom(32'h5EED);
        for (int i = 0; i < 64; i++) model[i] = 8'h00;

        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        check(miso_oe == 1'b0, "R1 oe low after reset", miso_oe, 0);
        check(miso == 1'b0, "R1 miso low after reset", miso, 0);
        read_frame(1'b1, 6'd0, 64, "R1 register resets to zero");

        // R2: enable follows select
        sel();
        check(miso_oe == 1'b1, "R2 oe high while selected", miso_oe, 1);
        cs_n = 1'b1;
        wait_cyc(H);
        check(miso_oe == 1'b0, "R2 oe low after deselect", miso_oe, 0);
        wait_cyc(H);

        // R6: auto-increment wraps 63 -> 0
        b[0] = 8'h11; b[1] = 8'h22; b[2] = 8'h33; b[3] = 8'h00;
        write_frame(1'b1, 6'd62, b, 3);
        read_frame(1'b1, 6'd62, 3, "R6 burst wrap readback");
        read_frame(1'b0, 6'd0, 1, "R6 byte wrapped to address 0");

        // R7: no increment, last write wins, repeated read same register
        b[0] = 8'hA1; b[1] = 8'hB2; b[2] = 8'hC3;
        write_frame(1'b0, 6'd10, b, 3);
        check(model[11] == 8'h00, "R7 neighbour untouched in model", model[11], 0);
        read_frame(1'b0, 6'd10, 3, "R7 fixed address read");
        read_frame(1'b0, 6'd11, 1, "R7 neighbour not written");

        // R8: abort mid-byte keeps earlier full byte only
        sel();
        xfer(cmd(1'b0, 1'b0, 6'd20), 8, 1'b0, rx);
        xfer(8'hA5, 8, 1'b0, rx);
        model[20] = 8'hA5;
        xfer(8'h3C, 4, 1'b0, rx);
        desel();
        read_frame(1'b0, 6'd20, 1, "R8 partial byte dropped");
        // R8: abort inside a command byte, then a clean frame
        sel();
        xfer(cmd(1'b0, 1'b0, 6'd21), 5, 1'b0, rx);
        desel();
        read_frame(1'b0, 6'd20, 1, "R8 new frame after command abort");

        // Random mix (R3 R4 R5 R9)
        for (int t = 0; t < 40; t++) begin
            bit         rd = 1'($urandom_range(0, 1));
            bit         inc = 1'($urandom_range(0, 1));
            logic [5:0] a = 6'($urandom_range(0, 63));
            int         n = $urandom_range(1, 4);
            if (rd) begin
                read_frame(inc, a, n, "R3 R5 R9 random read");
            end else begin
                for (int k = 0; k < 4; k++) b[k] = 8'($urandom);
                write_frame(inc, a, b, n);
                read_frame(inc, a, n, "R3 R4 random write readback");
            end
        end

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule